// File: doc/BRIEF.md
# ALU Status Flag Generator

This block keeps a 16-bit processor status word next to an ALU. After each arithmetic, logic or shift operation the datapath presents the operation class, the operand width, both operands, the result and its carry-out. On the next clock edge the block derives six condition flags from these values and registers them. The condition flags are carry, parity, nibble carry, zero, sign and signed overflow. The datapath itself is not part of this block.

Three control flags sit in the same word: string direction, interrupt enable and single-step trap. These change only through explicit set, clear or full-word load commands. A full-word load restores the whole register, for example when returning from an interrupt. The current word is always visible on one output port. Bit positions are fixed, because decode and interrupt logic elsewhere in the chip read individual bits.

Top module: `sflag_unit`

## Requirements
- R1: Flag bit positions are carry=0, parity=2, nibble carry=4, zero=6, sign=7, trap=8, interrupt enable=9, direction=10, overflow=11; after reset all flags are 0 and the word reads 16'h0002.
- R2: The carry flag takes `opCarry` for opClass 0 (add), 1 (subtract, borrow out) and 3 (shift/rotate, last bit shifted out); for opClass 2 (logic) it is cleared.
- R3: For add and subtract the nibble carry flag is opA[4]^opB[4]^opResult[4]; for logic and shift it is cleared.
- R4: The MSB is bit 7 when opWide=0 and bit 15 when opWide=1. The sign flag copies the result MSB. The zero flag is 1 when the result bits up to that MSB are all zero, and result bits above the MSB are ignored.
- R5: The parity flag is 1 when opResult[7:0] holds an even number of one bits.
- R6: For add, overflow = (A.msb==B.msb) and (R.msb!=A.msb). For subtract (A minus B), overflow = (A.msb!=B.msb) and (R.msb!=A.msb). For logic and shift it is cleared.
- R7: Operations never change the trap, interrupt enable or direction flags.
- R8: ctlCmd=3 loads `loadWord` into all nine flags. It wins over a same-cycle operation and is applied on the next edge.
- R9: Bits 1, 3, 5 and 12 to 15 read constant (bit 1 as 1, the rest as 0) whatever is loaded.
- R10: When opValid=0 and no load is commanded, the condition flags hold their values.
- R11: ctlCmd=1 sets and ctlCmd=2 clears one control flag chosen by ctlSel (0 direction, 1 interrupt enable, 2 trap). ctlSel=3 has no effect, and ctlCmd=0 does nothing.
- R12: An operation or command presented before a clock edge shows on `statusWord` after that edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An ALU operation completes this cycle |
| opClass | input | 2 | 0 add, 1 subtract, 2 logic, 3 shift/rotate |
| opWide | input | 1 | 1 for a 16-bit operation, 0 for 8-bit |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| opResult | input | 16 | Result from the datapath |
| opCarry | input | 1 | Carry/borrow out, or last bit shifted out |
| ctlCmd | input | 2 | 0 none, 1 set, 2 clear, 3 load word |
| ctlSel | input | 2 | Control flag chosen for set or clear |
| loadWord | input | 16 | Word written by a load command |
| statusWord | output | 16 | Current status word |

## Verification
On every cycle, the assertions check the following:
- control flags stay put unless a command names them;
- condition flags hold when no operation arrives;
- a logic operation leaves carry, overflow and nibble carry cleared;
- a load lands as the masked word;
- a zero word result raises the zero flag.

Only the bench's scenarios can show the exact flag values for each case:
- signed overflow in both directions;
- borrow;
- byte results with garbage in the upper byte;
- parity of the low byte;
- shifted-out carry.

The scenarios also show that a load beats an operation in the same cycle, and that selector 3 changes nothing.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int CTL_N  = 3;
  localparam int NIB_BIT = 4;

  localparam int POS_CARRY = 0;
  localparam int POS_PAR   = 2;
  localparam int POS_AUX   = 4;
  localparam int POS_ZERO  = 6;
  localparam int POS_SIGN  = 7;
  localparam int POS_TRAP  = 8;
  localparam int POS_INTR  = 9;
  localparam int POS_DIR   = 10;
  localparam int POS_OVF   = 11;

  localparam int SEL_DIR  = 0;
  localparam int SEL_INTR = 1;
  localparam int SEL_TRAP = 2;

  localparam logic [WORD_W-1:0] FIXED_ONES = 16'h0002;
  localparam logic [WORD_W-1:0] LIVE_MASK  = 16'h0FD5;

  typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_LOGIC, OP_SHIFT} op_class_e;
  typedef enum logic [1:0] {CMD_NONE, CMD_SET, CMD_CLEAR, CMD_LOAD} ctl_cmd_e;

  typedef struct packed {
    logic             condUpd;
    logic             wordLoad;
    logic [CTL_N-1:0] ctlSet;
    logic [CTL_N-1:0] ctlClr;
  } strobe_t;
endpackage

// File: rtl/sflag_ctrl.sv
module sflag_ctrl
  import sflag_pkg::*;
(
  input  logic     opValid,
  input  ctl_cmd_e ctlCmd,
  input  logic [1:0] ctlSel,
  output strobe_t  strb
);
  always_comb begin
    strb.wordLoad = (ctlCmd == CMD_LOAD);
    // R8: a load overrides any operation in the same cycle
    strb.condUpd  = opValid && (ctlCmd != CMD_LOAD);
  end

  for (genvar i = 0; i < CTL_N; i++) begin : g_sel
    always_comb begin
      strb.ctlSet[i] = (ctlCmd == CMD_SET)   && (ctlSel == 2'(i));
      strb.ctlClr[i] = (ctlCmd == CMD_CLEAR) && (ctlSel == 2'(i));
    end
  end
endmodule

// File: rtl/sflag_datapath.sv
module sflag_datapath
  import sflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  op_class_e         opClass,
  input  logic              opWide,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [WORD_W-1:0] opResult,
  input  logic              opCarry,
  input  logic [WORD_W-1:0] loadWord,
  output logic [WORD_W-1:0] statusWord
);
  logic cfQ, pfQ, afQ, zfQ, sfQ, ofQ;
  logic [CTL_N-1:0] ctlQ;

  logic aMsb, bMsb, rMsb, isArith;
  logic [WORD_W-1:0] rView;
  logic cfNext, pfNext, afNext, zfNext, sfNext, ofNext;

  always_comb begin
    aMsb    = opWide ? opA[WORD_W-1]      : opA[BYTE_W-1];
    bMsb    = opWide ? opB[WORD_W-1]      : opB[BYTE_W-1];
    rMsb    = opWide ? opResult[WORD_W-1] : opResult[BYTE_W-1];
    rView   = opWide ? opResult : {{(WORD_W-BYTE_W){1'b0}}, opResult[BYTE_W-1:0]};
    isArith = (opClass == OP_ADD) || (opClass == OP_SUB);
    cfNext  = (opClass != OP_LOGIC) && opCarry;
    afNext  = isArith && (opA[NIB_BIT] ^ opB[NIB_BIT] ^ opResult[NIB_BIT]);
    pfNext  = ~^opResult[BYTE_W-1:0];
    zfNext  = (rView == '0);
    sfNext  = rMsb;
    unique case (opClass)
      OP_ADD:  ofNext = (aMsb == bMsb) && (rMsb != aMsb);
      OP_SUB:  ofNext = (aMsb != bMsb) && (rMsb != aMsb);
      default: ofNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cfQ, pfQ, afQ, zfQ, sfQ, ofQ} <= '0;
    end else if (strb.wordLoad) begin
      cfQ <= loadWord[POS_CARRY];
      pfQ <= loadWord[POS_PAR];
      afQ <= loadWord[POS_AUX];
      zfQ <= loadWord[POS_ZERO];
      sfQ <= loadWord[POS_SIGN];
      ofQ <= loadWord[POS_OVF];
    end else if (strb.condUpd) begin
      cfQ <= cfNext;
      pfQ <= pfNext;
      afQ <= afNext;
      zfQ <= zfNext;
      sfQ <= sfNext;
      ofQ <= ofNext;
    end
  end

  logic [CTL_N-1:0] ctlLoadBits;
  always_comb begin
    ctlLoadBits[SEL_DIR]  = loadWord[POS_DIR];
    ctlLoadBits[SEL_INTR] = loadWord[POS_INTR];
    ctlLoadBits[SEL_TRAP] = loadWord[POS_TRAP];
  end

  for (genvar i = 0; i < CTL_N; i++) begin : g_ctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ctlQ[i] <= 1'b0;
      else if (strb.wordLoad)    ctlQ[i] <= ctlLoadBits[i];
      else if (strb.ctlSet[i])   ctlQ[i] <= 1'b1;
      else if (strb.ctlClr[i])   ctlQ[i] <= 1'b0;
    end
  end

  always_comb begin
    statusWord           = FIXED_ONES;
    statusWord[POS_CARRY] = cfQ;
    statusWord[POS_PAR]   = pfQ;
    statusWord[POS_AUX]   = afQ;
    statusWord[POS_ZERO]  = zfQ;
    statusWord[POS_SIGN]  = sfQ;
    statusWord[POS_TRAP]  = ctlQ[SEL_TRAP];
    statusWord[POS_INTR]  = ctlQ[SEL_INTR];
    statusWord[POS_DIR]   = ctlQ[SEL_DIR];
    statusWord[POS_OVF]   = ofQ;
  end

  assert_ctl_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.wordLoad && strb.ctlSet == '0 && strb.ctlClr == '0) |=> $stable(ctlQ));

  assert_cond_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.condUpd && !strb.wordLoad) |=> $stable({cfQ, pfQ, afQ, zfQ, sfQ, ofQ}));

  assert_logic_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.condUpd && opClass == OP_LOGIC) |=> (!cfQ && !ofQ && !afQ));

  assert_load_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wordLoad |=> statusWord == (($past(loadWord) & LIVE_MASK) | FIXED_ONES));

  assert_zero_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.condUpd && opWide && opResult == '0) |=> statusWord[POS_ZERO]);
endmodule

// File: rtl/sflag_unit.sv
module sflag_unit
  import sflag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        opValid,
  input  logic [1:0]  opClass,
  input  logic        opWide,
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic [15:0] opResult,
  input  logic        opCarry,
  input  logic [1:0]  ctlCmd,
  input  logic [1:0]  ctlSel,
  input  logic [15:0] loadWord,
  output logic [15:0] statusWord
);
  strobe_t strb;

  sflag_ctrl u_ctrl (
    .opValid (opValid),
    .ctlCmd  (ctl_cmd_e'(ctlCmd)),
    .ctlSel  (ctlSel),
    .strb    (strb)
  );

  sflag_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .opClass    (op_class_e'(opClass)),
    .opWide     (opWide),
    .opA        (opA),
    .opB        (opB),
    .opResult   (opResult),
    .opCarry    (opCarry),
    .loadWord   (loadWord),
    .statusWord (statusWord)
  );
endmodule

// File: tb/sim_sflag_unit.sv
module sim_sflag_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  cls;
    logic        wide;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] r;
    logic        c;
    logic [15:0] exp;
  } vec_t;

  // Expected words: C=0001 P=0004 A=0010 Z=0040 S=0080 O=0800, bit1 constant 1
  localparam vec_t VECS [10] = '{
    '{2'd0, 1'b0, 16'h007F, 16'h0001, 16'h0080, 1'b0, 16'h0892}, // R6 add overflow, R3 aux
    '{2'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b1, 16'h0057}, // R2 carry, R4 zero, R5
    '{2'd1, 1'b1, 16'h8000, 16'h0001, 16'h7FFF, 1'b0, 16'h0816}, // R6 sub overflow
    '{2'd1, 1'b1, 16'h0001, 16'h0002, 16'hFFFF, 1'b1, 16'h0097}, // R2 borrow, R4 sign
    '{2'd2, 1'b0, 16'h00F0, 16'h000F, 16'h00FF, 1'b1, 16'h0086}, // R2 logic clears carry
    '{2'd2, 1'b1, 16'h1234, 16'h0000, 16'h0000, 1'b0, 16'h0046}, // R4 word zero
    '{2'd3, 1'b0, 16'h0081, 16'h0001, 16'h0002, 1'b1, 16'h0003}, // R2 shift carry, R5 odd
    '{2'd3, 1'b1, 16'h4000, 16'h0001, 16'h8000, 1'b0, 16'h0086}, // R4 word sign
    '{2'd0, 1'b0, 16'h0010, 16'h0010, 16'hAB00, 1'b0, 16'h0046}, // R4 byte ignores high bits
    '{2'd0, 1'b1, 16'h0008, 16'h0008, 16'h0010, 1'b0, 16'h0012}  // R3 nibble carry
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic opValid, opWide, opCarry;
  logic [1:0] opClass, ctlCmd, ctlSel;
  logic [15:0] opA, opB, opResult, loadWord, statusWord;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sflag_unit u0 (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opClass(opClass), .opWide(opWide),
    .opA(opA), .opB(opB), .opResult(opResult), .opCarry(opCarry),
    .ctlCmd(ctlCmd), .ctlSel(ctlSel), .loadWord(loadWord), .statusWord(statusWord)
  );

  task automatic setIdle();
    opValid = 0; opClass = 0; opWide = 0; opA = 0; opB = 0; opResult = 0;
    opCarry = 0; ctlCmd = 0; ctlSel = 0; loadWord = 0;
  endtask

  task automatic check(string tag, logic [15:0] exp);
    checks++;
    if (statusWord !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, statusWord, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    setIdle();
  endtask

  task automatic driveOp(logic [1:0] cls, logic wide, logic [15:0] a, logic [15:0] b,
                         logic [15:0] r, logic c);
    opValid = 1; opClass = cls; opWide = wide; opA = a; opB = b; opResult = r; opCarry = c;
  endtask

  task automatic driveCmd(logic [1:0] cmd, logic [1:0] sel, logic [15:0] w);
    ctlCmd = cmd; ctlSel = sel; loadWord = w;
  endtask

  initial begin
    setIdle();
    repeat (3) @(negedge clk);
    check("R1 reset value", 16'h0002);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      driveOp(VECS[i].cls, VECS[i].wide, VECS[i].a, VECS[i].b, VECS[i].r, VECS[i].c);
      step();
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", i), VECS[i].exp);
    end

    driveCmd(2'd3, 2'd0, 16'h0000); step();
    check("R9 load zero keeps bit1", 16'h0002);
    driveCmd(2'd3, 2'd0, 16'hFFFF); step();
    check("R8 R9 load all ones masked", 16'h0FD7);

    driveOp(2'd2, 1'b0, 16'h0001, 16'h0001, 16'h0001, 1'b1); step();
    check("R7 op keeps control flags", 16'h0702);

    driveCmd(2'd2, 2'd0, 16'h0); step(); check("R11 clear direction", 16'h0302);
    driveCmd(2'd2, 2'd1, 16'h0); step(); check("R11 clear interrupt", 16'h0102);
    driveCmd(2'd2, 2'd2, 16'h0); step(); check("R11 clear trap", 16'h0002);
    driveCmd(2'd1, 2'd1, 16'h0); step(); check("R11 set interrupt", 16'h0202);
    driveCmd(2'd1, 2'd3, 16'hFFFF); step(); check("R11 selector 3 no effect", 16'h0202);
    driveCmd(2'd0, 2'd0, 16'hFFFF); step(); check("R11 no command no effect", 16'h0202);

    opValid = 0; opClass = 2'd0; opA = 16'h00FF; opB = 16'h0001; opResult = 0; opCarry = 1;
    step();
    check("R10 invalid op holds flags", 16'h0202);

    driveOp(2'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b1);
    driveCmd(2'd3, 2'd0, 16'h0040); step();
    check("R8 load wins over op", 16'h0042);

    driveOp(2'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b1);
    #1;
    check("R12 no change before edge", 16'h0042);
    step();
    check("R12 change after edge", 16'h0057);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 10000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule